// File: doc/BRIEF.md
# Charge and Temperature Threshold Alarm with Interrupt Routing

This block watches two measurement registers of a battery monitor: the signed charge accumulator and the signed temperature reading, which carries three fraction bits (one eighth of a degree). The temperature is first reduced to whole degrees by rounding toward minus infinity. Each value is then compared against its own programmable upper and lower limit. When a value moves into an out-of-range condition and the interrupt enable is set, the block alerts the host. It does this on one of two outputs, selected by a route bit.

On the serial data line the alert is a long low pulse, as long as a bus reset. The pulse is only started while the line is idle high. Its length is a whole number of prescaler ticks. On the general-purpose pin the alert pulls the pin low and keeps it low until the host writes 1 to the pin control bit. When no alert holds it, that same pin is plain open-drain I/O under host control. A write of 0 pulls the pin low, a write of 1 releases it, and a read returns the level seen on the pad. A bus reset clears the interrupt enable. A sleep indication releases the pin and forces its control bit to 1. The block only produces pull-down enables; the pad drivers lie outside it.

Top module: `alarm_irq_top`

## Requirements
- R1: After reset, both pull-down enables (`dq_pull`, `pin_pull`) are 0, the interrupt enable is 0 and the pin control bit is 1 (released).
- R2: A charge alarm fires when `acc_val`, taken as signed, becomes greater than or equal to `acc_hi_lim`; equality counts.
- R3: A charge alarm fires when `acc_val`, taken as signed, becomes less than or equal to `acc_lo_lim`; equality counts.
- R4: The temperature in whole degrees is `temp_val` arithmetically shifted right by 3 (floor, so raw -1 gives -1 °C). It raises an alarm when it becomes >= `temp_hi_lim` or <= `temp_lo_lim`, both of which are 8-bit signed values.
- R5: Alarms fire on entry into an out-of-range condition only. A value that stays out of range raises no further alarm. Leaving the range and re-entering it raises a new alarm. A condition already present when the enable is set raises none.
- R6: While the interrupt enable is 0, crossings drive neither output.
- R7: `bus_reset` clears the interrupt enable, and it wins over an enable write in the same cycle. `ie_wr` loads `ie_wdata` into the enable.
- R8: With `route_sel` = 1, an alarm asserts `dq_pull` for exactly TICK_DIV*PULSE_TICKS clock cycles (24 by default) and leaves `pin_pull` untouched.
- R9: The data-line pulse starts only in a cycle where `dq_in` is 1. An alarm raised while `dq_in` is 0 is held and launched once the line is high.
- R10: With `route_sel` = 0, an alarm sets the pin control bit to 0 (`pin_pull` = 1). It stays so until the host writes 1, whatever the monitored values do.
- R11: A pin write (`pin_wr`) loads `pin_wdata` into the control bit: 0 asserts `pin_pull`, 1 releases it. `pin_rd` always equals `pin_in`.
- R12: While `sleep_req` is 1, the control bit is forced to 1 on every clock. Host writes of 0 and pin alarms are overridden, and the pin stays released after sleep ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_val | input | ACC_W | Charge accumulator value, signed |
| acc_hi_lim | input | ACC_W | Upper charge limit, signed |
| acc_lo_lim | input | ACC_W | Lower charge limit, signed |
| temp_val | input | TEMP_W | Temperature, signed, TEMP_FRAC fraction bits |
| temp_hi_lim | input | TLIM_W | Upper temperature limit in whole degrees, signed |
| temp_lo_lim | input | TLIM_W | Lower temperature limit in whole degrees, signed |
| ie_wr | input | 1 | Write strobe for the interrupt enable |
| ie_wdata | input | 1 | Value written to the interrupt enable |
| route_sel | input | 1 | 1 routes alarms to the data line, 0 to the pin |
| bus_reset | input | 1 | Serial bus reset seen, one cycle |
| sleep_req | input | 1 | Sleep or long-low data line indication |
| pin_wr | input | 1 | Write strobe for the pin control bit |
| pin_wdata | input | 1 | Value written to the pin control bit |
| pin_in | input | 1 | Level sensed on the pin pad |
| dq_in | input | 1 | Level sensed on the data line |
| dq_pull | output | 1 | Pull-down enable for the data line |
| pin_pull | output | 1 | Pull-down enable for the pin |
| pin_rd | output | 1 | Pin level returned to the host |

## Verification
The hardest situation to reach is a data-line alarm that has to wait. The crossing must occur while the bus is held low, so the alarm sits pending with no visible effect. The bench holds `dq_in` low across the crossing and for several further cycles, confirming nothing is driven. It then releases the line and expects the pulse on the next cycle. A second hard case is the enable being set while a value is already out of range. The bench reaches it by moving the accumulator past its limit while the enable is off, then enabling and expecting silence until the value leaves and re-enters the range.

// File: rtl/alarm_irq_pkg.sv
// Package: shared route encoding and crossing indices for the alarm block.
// Assumes: nothing beyond standard SystemVerilog.
package alarm_irq_pkg;

    typedef enum logic {
        ROUTE_PIN = 1'b0,
        ROUTE_DQ  = 1'b1
    } irq_route_e;

    typedef enum int {
        XC_ACC_HI  = 0,
        XC_ACC_LO  = 1,
        XC_TEMP_HI = 2,
        XC_TEMP_LO = 3
    } cross_idx_e;

    localparam int NUM_CROSS = 4;

endpackage

// File: rtl/alarm_cross.sv
// Module: signed limit comparator with entry-edge detection.
// What it does: flags the cycle in which 'value' enters the region at or
// beyond 'limit' (>= when UPPER=1, <= when UPPER=0).
// Assumes: value and limit are two's complement of the same width.
module alarm_cross #(
    parameter int W     = 16,
    parameter bit UPPER = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] value,
    input  logic [W-1:0] limit,
    output logic         entered
);

    logic beyond;
    logic beyond_q;

    generate
        if (UPPER) begin : g_upper
            // Purpose: upper-limit test, equality included.
            always_comb beyond = $signed(value) >= $signed(limit);
        end else begin : g_lower
            // Purpose: lower-limit test, equality included.
            always_comb beyond = $signed(value) <= $signed(limit);
        end
    endgenerate

    // Purpose: remember last cycle's condition so only entry is reported.
    always_ff @(posedge clk) begin
        if (!rst_n) beyond_q <= 1'b0;
        else        beyond_q <= beyond;
    end

    assign entered = beyond & ~beyond_q;

endmodule

// File: rtl/irq_pin_ctl.sv
// Module: control bit of the dual-purpose open-drain pin.
// What it does: holds the host-written control bit; a routed alarm clears
// it (pin pulled low) and sleep forces it to 1.
// Assumes: priority sleep > host write > alarm.
module irq_pin_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic alarm,
    input  logic wr,
    input  logic wdata,
    input  logic sleep_req,
    output logic pull
);

    logic ctl_q;

    // Purpose: update the control bit by priority.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctl_q <= 1'b1;
        else if (sleep_req) ctl_q <= 1'b1;
        else if (wr)        ctl_q <= wdata;
        else if (alarm)     ctl_q <= 1'b0;
    end

    assign pull = ~ctl_q;

endmodule

// File: rtl/irq_dq_pulse.sv
// Module: reset-length low pulse generator for the shared data line.
// What it does: on an alarm (or one held pending) and with the line idle
// high, drives the pull-down for TICK_DIV*PULSE_TICKS clock cycles.
// Assumes: TICK_DIV >= 1 and PULSE_TICKS >= 1.
module irq_dq_pulse #(
    parameter int TICK_DIV    = 4,
    parameter int PULSE_TICKS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alarm,
    input  logic dq_in,
    output logic pull
);

    localparam int DIV_W  = (TICK_DIV    > 1) ? $clog2(TICK_DIV)    : 1;
    localparam int TICK_W = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
    localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(TICK_DIV - 1);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(PULSE_TICKS - 1);

    logic              busy_q;
    logic              pend_q;
    logic [DIV_W-1:0]  div_q;
    logic [TICK_W-1:0] tick_q;
    logic              launch;

    assign launch = (alarm | pend_q) & dq_in & ~busy_q;

    // Purpose: hold an alarm that could not be launched yet.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (launch) pend_q <= 1'b0;
        else if (alarm)  pend_q <= 1'b1;
    end

    // Purpose: time the pulse in prescaled ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            div_q  <= '0;
            tick_q <= '0;
        end else if (launch) begin
            busy_q <= 1'b1;
            div_q  <= '0;
            tick_q <= '0;
        end else if (busy_q) begin
            if (div_q == DIV_LAST) begin
                div_q <= '0;
                if (tick_q == TICK_LAST) busy_q <= 1'b0;
                else                     tick_q <= tick_q + 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign pull = busy_q;

endmodule

// File: rtl/alarm_irq_top.sv
// Module: threshold alarm with selectable interrupt output.
// What it does: scales temperature to whole degrees, detects entry past
// four signed limits, gates by the interrupt enable and routes the alarm
// to the data-line pulser or the pin control bit.
// Assumes: synchronous inputs; bus_reset is a one-cycle strobe.
module alarm_irq_top
    import alarm_irq_pkg::*;
#(
    parameter int ACC_W       = 16,
    parameter int TEMP_W      = 11,
    parameter int TEMP_FRAC   = 3,
    parameter int TLIM_W      = 8,
    parameter int TICK_DIV    = 4,
    parameter int PULSE_TICKS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACC_W-1:0]  acc_val,
    input  logic [ACC_W-1:0]  acc_hi_lim,
    input  logic [ACC_W-1:0]  acc_lo_lim,
    input  logic [TEMP_W-1:0] temp_val,
    input  logic [TLIM_W-1:0] temp_hi_lim,
    input  logic [TLIM_W-1:0] temp_lo_lim,
    input  logic              ie_wr,
    input  logic              ie_wdata,
    input  logic              route_sel,
    input  logic              bus_reset,
    input  logic              sleep_req,
    input  logic              pin_wr,
    input  logic              pin_wdata,
    input  logic              pin_in,
    input  logic              dq_in,
    output logic              dq_pull,
    output logic              pin_pull,
    output logic              pin_rd
);

    localparam int TS_W = TEMP_W - TEMP_FRAC;
    localparam int TC_W = (TS_W > TLIM_W) ? TS_W : TLIM_W;

    logic                 ie_q;
    logic [TS_W-1:0]      temp_deg;
    logic [TC_W-1:0]      temp_cmp;
    logic [TC_W-1:0]      thi_cmp;
    logic [TC_W-1:0]      tlo_cmp;
    logic [NUM_CROSS-1:0] entered;
    logic                 alarm;
    irq_route_e           route;

    // Upper bits of a two's complement value are its floor division.
    assign temp_deg = temp_val[TEMP_W-1:TEMP_FRAC];
    assign temp_cmp = TC_W'($signed(temp_deg));
    assign thi_cmp  = TC_W'($signed(temp_hi_lim));
    assign tlo_cmp  = TC_W'($signed(temp_lo_lim));

    // Purpose: interrupt enable, cleared by any bus reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         ie_q <= 1'b0;
        else if (bus_reset) ie_q <= 1'b0;
        else if (ie_wr)     ie_q <= ie_wdata;
    end

    alarm_cross #(.W(ACC_W), .UPPER(1'b1)) u_acc_hi (
        .clk(clk), .rst_n(rst_n), .value(acc_val), .limit(acc_hi_lim),
        .entered(entered[XC_ACC_HI]));
    alarm_cross #(.W(ACC_W), .UPPER(1'b0)) u_acc_lo (
        .clk(clk), .rst_n(rst_n), .value(acc_val), .limit(acc_lo_lim),
        .entered(entered[XC_ACC_LO]));
    alarm_cross #(.W(TC_W), .UPPER(1'b1)) u_tmp_hi (
        .clk(clk), .rst_n(rst_n), .value(temp_cmp), .limit(thi_cmp),
        .entered(entered[XC_TEMP_HI]));
    alarm_cross #(.W(TC_W), .UPPER(1'b0)) u_tmp_lo (
        .clk(clk), .rst_n(rst_n), .value(temp_cmp), .limit(tlo_cmp),
        .entered(entered[XC_TEMP_LO]));

    assign alarm = ie_q & (|entered);
    assign route = irq_route_e'(route_sel);

    irq_dq_pulse #(.TICK_DIV(TICK_DIV), .PULSE_TICKS(PULSE_TICKS)) u_dq (
        .clk(clk), .rst_n(rst_n),
        .alarm(alarm && route == ROUTE_DQ),
        .dq_in(dq_in), .pull(dq_pull));

    irq_pin_ctl u_pin (
        .clk(clk), .rst_n(rst_n),
        .alarm(alarm && route == ROUTE_PIN),
        .wr(pin_wr), .wdata(pin_wdata), .sleep_req(sleep_req),
        .pull(pin_pull));

    assign pin_rd = pin_in;

endmodule

// File: rtl/alarm_irq_chk.sv
// Module: property checker for alarm_irq_top, attached by bind below.
// Assumes: PULSE_LEN equals the top's TICK_DIV*PULSE_TICKS.
module alarm_irq_chk #(
    parameter int PULSE_LEN = 24
) (
    input logic clk,
    input logic rst_n,
    input logic dq_in,
    input logic dq_pull,
    input logic pin_pull,
    input logic pin_wr,
    input logic pin_wdata,
    input logic sleep_req,
    input logic bus_reset,
    input logic ie_q
);

    int unsigned hi_cnt;

    // Purpose: count consecutive cycles with the data-line pull asserted.
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_cnt <= 0;
        else if (dq_pull) hi_cnt <= hi_cnt + 1;
        else              hi_cnt <= 0;
    end

    assert_pulse_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_pull) |-> hi_cnt == PULSE_LEN);

    assert_launch_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_pull) |-> $past(dq_in));

    assert_pin_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_pull) |-> ($past(ie_q) || $past(pin_wr && !pin_wdata)));

    assert_pin_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pull && !pin_wr && !sleep_req) |=> pin_pull);

    assert_sleep_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> !pin_pull);

    assert_busreset_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !ie_q);

endmodule

bind alarm_irq_top alarm_irq_chk #(.PULSE_LEN(TICK_DIV * PULSE_TICKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .dq_in(dq_in), .dq_pull(dq_pull),
    .pin_pull(pin_pull), .pin_wr(pin_wr), .pin_wdata(pin_wdata),
    .sleep_req(sleep_req), .bus_reset(bus_reset), .ie_q(ie_q));

// File: tb/sim_alarm_irq_top.sv
module sim_alarm_irq_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] acc_val, acc_hi_lim, acc_lo_lim;
    logic [10:0] temp_val;
    logic [7:0]  temp_hi_lim, temp_lo_lim;
    logic        ie_wr, ie_wdata, route_sel, bus_reset, sleep_req;
    logic        pin_wr, pin_wdata, pin_in, dq_in;
    logic        dq_pull, pin_pull, pin_rd;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    alarm_irq_top u0 (
        .clk(clk), .rst_n(rst_n), .acc_val(acc_val), .acc_hi_lim(acc_hi_lim),
        .acc_lo_lim(acc_lo_lim), .temp_val(temp_val), .temp_hi_lim(temp_hi_lim),
        .temp_lo_lim(temp_lo_lim), .ie_wr(ie_wr), .ie_wdata(ie_wdata),
        .route_sel(route_sel), .bus_reset(bus_reset), .sleep_req(sleep_req),
        .pin_wr(pin_wr), .pin_wdata(pin_wdata), .pin_in(pin_in), .dq_in(dq_in),
        .dq_pull(dq_pull), .pin_pull(pin_pull), .pin_rd(pin_rd));

    // kind: 0 = R2 upper charge, 1 = R3 lower charge, 2 = R4 temperature
    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] acc;
        logic [10:0] temp;
        logic        exp;
    } vec_t;

    // limits: charge +1000 / -1000, temperature +30 / -1 degrees
    localparam vec_t VEC [12] = '{
        '{2'd0, 16'h03E7, 11'd80,   1'b0},  // R2 999 below limit
        '{2'd0, 16'h03E8, 11'd80,   1'b1},  // R2 equal to limit
        '{2'd0, 16'h7FFF, 11'd80,   1'b1},  // R2 maximum
        '{2'd1, 16'hFC19, 11'd80,   1'b0},  // R3 -999
        '{2'd1, 16'hFC18, 11'd80,   1'b1},  // R3 -1000 equal
        '{2'd1, 16'h8000, 11'd80,   1'b1},  // R3 minimum
        '{2'd2, 16'h0000, 11'd239,  1'b0},  // R4 29.875 -> 29
        '{2'd2, 16'h0000, 11'd240,  1'b1},  // R4 30.0
        '{2'd2, 16'h0000, 11'd0,    1'b0},  // R4 0 degrees
        '{2'd2, 16'h0000, 11'h7FF,  1'b1},  // R4 -0.125 -> -1
        '{2'd2, 16'h0000, 11'h7F8,  1'b1},  // R4 -1.0
        '{2'd2, 16'h0000, 11'h7F0,  1'b1}   // R4 -2.0
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pin_write(input logic v);
        pin_wr = 1'b1; pin_wdata = v;
        tick();
        pin_wr = 1'b0;
    endtask

    task automatic ie_write(input logic v);
        ie_wr = 1'b1; ie_wdata = v;
        tick();
        ie_wr = 1'b0;
    endtask

    task automatic neutral();
        acc_val = 16'h0000; temp_val = 11'd80;
        tick();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int n;
        rst_n = 1'b0;
        acc_val = 16'h0; acc_hi_lim = 16'd1000; acc_lo_lim = 16'hFC18;
        temp_val = 11'd80; temp_hi_lim = 8'd30; temp_lo_lim = 8'hFF;
        ie_wr = 0; ie_wdata = 0; route_sel = 0; bus_reset = 0; sleep_req = 0;
        pin_wr = 0; pin_wdata = 0; pin_in = 1; dq_in = 1;
        @(negedge clk);
        tick(); tick();
        chk("R1 dq_pull in reset", dq_pull, 0);
        chk("R1 pin_pull in reset", pin_pull, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 pin_pull after reset", pin_pull, 0);

        // R6: enable off, crossing drives nothing
        acc_val = 16'd2000;
        tick(); tick();
        chk("R6 pin idle with enable off", pin_pull, 0);
        chk("R6 dq idle with enable off", dq_pull, 0);
        // R5: enable set while already beyond: no alarm
        ie_write(1'b1);
        tick();
        chk("R5 no alarm for preexisting condition", pin_pull, 0);
        neutral();

        // Vector table, pin route, enable on
        foreach (VEC[i]) begin
            acc_val = VEC[i].acc; temp_val = VEC[i].temp;
            tick();
            case (VEC[i].kind)
                2'd0:    chk("R2 upper charge crossing", pin_pull, int'(VEC[i].exp));
                2'd1:    chk("R3 lower charge crossing", pin_pull, int'(VEC[i].exp));
                default: chk("R4 scaled temperature crossing", pin_pull, int'(VEC[i].exp));
            endcase
            acc_val = 16'h0; temp_val = 11'd80;
            pin_write(1'b1);
            tick();
        end

        // R10 and R5: latched, one alarm per entry
        acc_val = 16'd2000;
        tick();
        chk("R10 pin alarm asserted", pin_pull, 1);
        acc_val = 16'd0;
        repeat (5) tick();
        chk("R10 pin held after value returns", pin_pull, 1);
        acc_val = 16'd2000;
        tick();
        pin_write(1'b1);
        repeat (4) tick();
        chk("R5 no repeat while still beyond", pin_pull, 0);
        neutral();
        acc_val = 16'd2000;
        tick();
        chk("R5 re-entry raises new alarm", pin_pull, 1);
        pin_write(1'b1);
        neutral();

        // R7: bus reset clears enable; wins over same-cycle write
        bus_reset = 1'b1; tick(); bus_reset = 1'b0;
        acc_val = 16'd2000; tick();
        chk("R7 enable cleared by bus reset", pin_pull, 0);
        neutral();
        bus_reset = 1'b1; ie_wr = 1'b1; ie_wdata = 1'b1;
        tick();
        bus_reset = 1'b0; ie_wr = 1'b0;
        acc_val = 16'd2000; tick();
        chk("R7 bus reset wins over enable write", pin_pull, 0);
        neutral();
        ie_write(1'b1);
        acc_val = 16'd2000; tick();
        chk("R7 enable write restores alarms", pin_pull, 1);
        pin_write(1'b1);
        neutral();

        // R8: data-line pulse length, pin untouched
        route_sel = 1'b1;
        acc_val = 16'd2000;
        tick();
        n = 0;
        while (dq_pull && n < 100) begin
            if (pin_pull) n = 1000;
            n++;
            tick();
        end
        chk("R8 data-line pulse cycles", n, 24);
        chk("R8 pin untouched on data route", pin_pull, 0);
        neutral();

        // R9: deferred while line low
        dq_in = 1'b0;
        acc_val = 16'd2000;
        repeat (8) tick();
        chk("R9 no pulse while line low", dq_pull, 0);
        dq_in = 1'b1;
        tick();
        chk("R9 pulse starts once line high", dq_pull, 1);
        repeat (30) tick();
        chk("R9 pulse finished", dq_pull, 0);
        neutral();
        route_sel = 1'b0;

        // R11: plain open-drain I/O
        pin_write(1'b0);
        chk("R11 write 0 pulls pin", pin_pull, 1);
        pin_write(1'b1);
        chk("R11 write 1 releases pin", pin_pull, 0);
        pin_in = 1'b0; #1;
        chk("R11 read returns pad low", pin_rd, 0);
        pin_in = 1'b1; #1;
        chk("R11 read returns pad high", pin_rd, 1);

        // R12: sleep forces release
        pin_write(1'b0);
        sleep_req = 1'b1;
        tick();
        chk("R12 sleep releases pin", pin_pull, 0);
        pin_write(1'b0);
        chk("R12 write 0 overridden in sleep", pin_pull, 0);
        acc_val = 16'd2000; tick();
        chk("R12 alarm overridden in sleep", pin_pull, 0);
        sleep_req = 1'b0;
        tick();
        chk("R12 pin stays released after sleep", pin_pull, 0);

        summary();
    end

endmodule